// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital side of a 12-bit successive-approximation converter. Software reaches it through a small byte-wide register port. It picks an input channel, a conversion-clock divider and an acquisition length, then sets a start bit. The sequencer latches the channel onto the analog multiplexer select and holds the sample switch closed for the programmed acquisition time. It then resolves the code one bit per conversion-clock period, most significant bit first, by driving a trial code to the DAC and reading back an external comparator.

When the last bit is resolved, the sequencer writes the code into the result register, drops the busy indication and raises an interrupt flag. The interrupt line only asserts while both the source enable and the global enable are set. After every conversion the sequencer holds off for two conversion-clock periods before another acquisition may begin. A start written during that hold-off is remembered and taken up once the hold-off ends.

Two reset inputs exist. The power-on/brown-out reset clears everything, including the result. The general reset clears everything except the result register.

Top module: `sar_adc_seq`

## Requirements
- R1: Register map. Address 0 is control: bit 0 enable, bit 1 start/busy, bits 5:2 channel. Address 1 is timing: bits 2:0 divider select, bits 5:3 acquisition select. Address 2 is interrupt: bit 0 flag, bit 1 source enable, bit 2 global enable. Address 3 gives result bits 11:8 in bits 3:0. Address 4 gives result bits 7:0. Unused bits and addresses read 0. After reset, addresses 0 to 2 read 0 and `irq` and `sampleHold` are 0.
- R2: Writing control with bits 0 and 1 both set while not busy makes busy read 1 from the next cycle on. One cycle later the sequence begins, and `chanSel` takes the channel field in effect at that cycle.
- R3: One conversion-clock period Tc is 2^(s+1) system clocks for divider select s = 0..5, and 64 for s = 6 or 7. Busy reads 1 for (A+12)*Tc+1 cycles, counted from the cycle after the start write.
- R4: `sampleHold` is 1 for exactly A*Tc cycles from the first cycle of the sequence. A is 0, 2, 4, 6, 8, 12, 16 or 20 for acquisition select 0..7. With A = 0, conversion starts at once and `sampleHold` stays 0.
- R5: Bits are resolved MSB first, one per Tc. A trial bit is kept when `cmpHigh` is 1 (input at or above `dacCode`) and cleared otherwise. With such a comparator, the result equals the input code, including 000h and FFFh.
- R6: (A+12)*Tc cycles after the sequence begins, busy clears, the flag sets and the result register updates, all on the same edge.
- R7: `irq` = flag AND source enable AND global enable. Writing interrupt bit 0 as 0 clears the flag. Writing it as 1 never sets it.
- R8: After each conversion, no acquisition begins for 2*Tc cycles. A start written in that gap is held and begins on the cycle after the gap.
- R9: A start written while busy has no effect. A channel written while busy changes neither `chanSel` nor the channel converted.
- R10: Writing enable as 0 aborts at once: busy 0, `sampleHold` 0, no flag and result unchanged. A start written with enable 0 is ignored.
- R11: `sysRst_n` resets every register except the result. `porRst_n` resets all of them and clears the result to 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porRst_n | input | 1 | Power-on / brown-out reset, active low, clears result |
| sysRst_n | input | 1 | General reset, active low, keeps result |
| regAddr | input | 3 | Register address |
| regWe | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational on address |
| cmpHigh | input | 1 | Comparator: input at or above DAC level |
| dacCode | output | 12 | Trial code to the DAC |
| chanSel | output | 4 | Analog multiplexer select |
| sampleHold | output | 1 | Sample switch closed (acquisition) |
| irq | output | 1 | Interrupt request |

## Verification
Conversions are run on a mid-scale pattern, on the all-zeros and all-ones codes and on alternating-bit codes. A bit-order or keep/clear error shows up as a wrong code on these, and the two end codes catch off-by-one trial handling. The same conversions are repeated across divider selects, including the two clamped codes, and across short, zero and long acquisition settings. Each case isolates the period arithmetic from the acquisition table. Further runs put a restart and a channel change mid-conversion, a start inside the post-conversion gap, an abort partway through, and each reset source. These separate the ignore, queue and abort paths, and show which registers survive which reset.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_GAP  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic latchCh;
    logic sarInit;
    logic sarStep;
    logic commit;
  } dpStrobe_t;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_TIME = 1;
  localparam int ADDR_INT  = 2;
  localparam int ADDR_RESH = 3;
  localparam int ADDR_RESL = 4;

  // acquisition length in conversion-clock periods for a 3-bit select
  function automatic int unsigned acqPeriods(input logic [2:0] code);
    if (code <= 3'd4) return 2 * int'(code);
    return 4 * (int'(code) - 2);
  endfunction

endpackage

// File: rtl/sar_seq_clkdiv.sv
module sar_seq_clkdiv #(
  parameter int SEL_W   = 3,
  parameter int MAX_LOG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] divSel,
  output logic             tick
);
  localparam int CNT_W = MAX_LOG;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastVal;
  int unsigned      selEff;

  always_comb begin
    selEff  = (int'(divSel) > MAX_LOG - 1) ? MAX_LOG - 1 : int'(divSel);
    lastVal = CNT_W'((1 << (selEff + 1)) - 1);
  end

  assign tick = run && (cnt == lastVal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int CH_W     = 4,
  parameter int SEL_W    = 3,
  parameter int ACQ_W    = 3,
  parameter int GAP_TADS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              tick,
  input  logic              lastBit,
  output logic              runDiv,
  output dpStrobe_t         strobe,
  output seqState_t         state,
  output logic              busyBit,
  output logic              enableBit,
  output logic              flagBit,
  output logic              ieBit,
  output logic              gieBit,
  output logic              irq,
  output logic [CH_W-1:0]   chField,
  output logic [SEL_W-1:0]  divSel,
  output logic [ACQ_W-1:0]  acqSel
);
  localparam int MAX_ACQ = 20;
  localparam int CNT_W   = $clog2(MAX_ACQ + 1);

  seqState_t        stateNext;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] acqLen;
  logic             cntClr, cntInc;
  logic             ctrlWr, timeWr, intWr;
  logic             enNext, startReq;
  logic [DATA_W-1:0] unusedWr;

  assign unusedWr = regWrData;
  assign ctrlWr   = regWe && (regAddr == ADDR_W'(ADDR_CTRL));
  assign timeWr   = regWe && (regAddr == ADDR_W'(ADDR_TIME));
  assign intWr    = regWe && (regAddr == ADDR_W'(ADDR_INT));
  assign enNext   = ctrlWr ? regWrData[0] : enableBit;
  assign startReq = ctrlWr && regWrData[1] && regWrData[0] && !busyBit;
  assign acqLen   = CNT_W'(acqPeriods(acqSel));
  assign runDiv   = (state != ST_IDLE);
  assign irq      = flagBit && ieBit && gieBit;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    cntClr    = 1'b0;
    cntInc    = 1'b0;
    unique case (state)
      ST_IDLE: if (busyBit) begin
        strobe.latchCh = 1'b1;
        cntClr         = 1'b1;
        if (acqLen == '0) begin
          stateNext      = ST_CONV;
          strobe.sarInit = 1'b1;
        end else begin
          stateNext = ST_ACQ;
        end
      end
      ST_ACQ: if (tick) begin
        if (phaseCnt == acqLen - 1'b1) begin
          stateNext      = ST_CONV;
          strobe.sarInit = 1'b1;
          cntClr         = 1'b1;
        end else begin
          cntInc = 1'b1;
        end
      end
      ST_CONV: if (tick) begin
        strobe.sarStep = 1'b1;
        if (lastBit) begin
          strobe.commit = 1'b1;
          stateNext     = ST_GAP;
          cntClr        = 1'b1;
        end
      end
      ST_GAP: if (tick) begin
        if (phaseCnt == CNT_W'(GAP_TADS - 1)) begin
          stateNext = ST_IDLE;
          cntClr    = 1'b1;
        end else begin
          cntInc = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    if (!enNext) begin
      stateNext = ST_IDLE;
      strobe    = '0;
      cntClr    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phaseCnt  <= '0;
      busyBit   <= 1'b0;
      enableBit <= 1'b0;
      flagBit   <= 1'b0;
      ieBit     <= 1'b0;
      gieBit    <= 1'b0;
      chField   <= '0;
      divSel    <= '0;
      acqSel    <= '0;
    end else begin
      state     <= stateNext;
      enableBit <= enNext;
      if (cntClr)      phaseCnt <= '0;
      else if (cntInc) phaseCnt <= phaseCnt + 1'b1;

      if (ctrlWr) chField <= regWrData[2 +: CH_W];
      if (timeWr) begin
        divSel <= regWrData[0 +: SEL_W];
        acqSel <= regWrData[SEL_W +: ACQ_W];
      end

      if (!enNext)            busyBit <= 1'b0;
      else if (strobe.commit) busyBit <= 1'b0;
      else if (startReq)      busyBit <= 1'b1;

      if (intWr) begin
        ieBit  <= regWrData[1];
        gieBit <= regWrData[2];
      end
      if (strobe.commit)                flagBit <= 1'b1;
      else if (intWr && !regWrData[0])  flagBit <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             porRst_n,
  input  dpStrobe_t        strobe,
  input  logic             cmpHigh,
  input  logic [CH_W-1:0]  chField,
  output logic [RES_W-1:0] sar,
  output logic [RES_W-1:0] result,
  output logic [CH_W-1:0]  chanSel,
  output logic             lastBit
);
  localparam int IDX_W = $clog2(RES_W);

  logic [IDX_W-1:0] bitIdx;
  logic [RES_W-1:0] sarNext;

  assign lastBit = (bitIdx == '0);

  for (genvar i = 0; i < RES_W; i++) begin : g_bit
    always_comb begin
      if (strobe.sarInit)
        sarNext[i] = (i == RES_W - 1);
      else if (strobe.sarStep && bitIdx == IDX_W'(i))
        sarNext[i] = cmpHigh;
      else if (strobe.sarStep && bitIdx != '0 && bitIdx - 1'b1 == IDX_W'(i))
        sarNext[i] = 1'b1;
      else
        sarNext[i] = sar[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar     <= '0;
      bitIdx  <= '0;
      chanSel <= '0;
    end else begin
      sar <= sarNext;
      if (strobe.sarInit)                 bitIdx <= IDX_W'(RES_W - 1);
      else if (strobe.sarStep && !lastBit) bitIdx <= bitIdx - 1'b1;
      if (strobe.latchCh) chanSel <= chField;
    end
  end

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n)         result <= '0;
    else if (strobe.commit) result <= sarNext;
  end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_seq_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int RES_W   = 12,
  parameter int CH_W    = 4,
  parameter int SEL_W   = 3,
  parameter int ACQ_W   = 3,
  parameter int MAX_LOG = 6
) (
  input  logic              clk,
  input  logic              porRst_n,
  input  logic              sysRst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              cmpHigh,
  output logic [RES_W-1:0]  dacCode,
  output logic [CH_W-1:0]   chanSel,
  output logic              sampleHold,
  output logic              irq
);
  logic             rstAll_n;
  logic             tick, lastBit, runDiv;
  dpStrobe_t        strobe;
  seqState_t        seqState;
  logic             busyBit, enableBit, flagBit, ieBit, gieBit;
  logic [CH_W-1:0]  chField;
  logic [SEL_W-1:0] divSel;
  logic [ACQ_W-1:0] acqSel;
  logic [RES_W-1:0] resultReg;

  assign rstAll_n   = porRst_n & sysRst_n;
  assign sampleHold = (seqState == ST_ACQ);

  sar_seq_clkdiv #(.SEL_W(SEL_W), .MAX_LOG(MAX_LOG)) u_div (
    .clk(clk), .rst_n(rstAll_n), .run(runDiv), .divSel(divSel), .tick(tick)
  );

  sar_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W),
    .SEL_W(SEL_W), .ACQ_W(ACQ_W), .GAP_TADS(2)
  ) u_ctrl (
    .clk(clk), .rst_n(rstAll_n), .regAddr(regAddr), .regWe(regWe),
    .regWrData(regWrData), .tick(tick), .lastBit(lastBit), .runDiv(runDiv),
    .strobe(strobe), .state(seqState), .busyBit(busyBit),
    .enableBit(enableBit), .flagBit(flagBit), .ieBit(ieBit), .gieBit(gieBit),
    .irq(irq), .chField(chField), .divSel(divSel), .acqSel(acqSel)
  );

  sar_seq_dp #(.RES_W(RES_W), .CH_W(CH_W)) u_dp (
    .clk(clk), .rst_n(rstAll_n), .porRst_n(porRst_n), .strobe(strobe),
    .cmpHigh(cmpHigh), .chField(chField), .sar(dacCode), .result(resultReg),
    .chanSel(chanSel), .lastBit(lastBit)
  );

  always_comb begin
    unique case (int'(regAddr))
      ADDR_CTRL: regRdData = DATA_W'({chField, busyBit, enableBit});
      ADDR_TIME: regRdData = DATA_W'({acqSel, divSel});
      ADDR_INT:  regRdData = DATA_W'({gieBit, ieBit, flagBit});
      ADDR_RESH: regRdData = DATA_W'(resultReg[RES_W-1:DATA_W]);
      ADDR_RESL: regRdData = resultReg[DATA_W-1:0];
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk
  import sar_seq_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CH_W  = 4
) (
  input logic             clk,
  input logic             rstAll_n,
  input seqState_t        seqState,
  input logic             busyBit,
  input logic             enableBit,
  input logic             flagBit,
  input logic             sampleHold,
  input logic [CH_W-1:0]  chanSel,
  input logic [RES_W-1:0] resultReg
);
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstAll_n)
    (seqState != ST_CONV) |=> $stable(resultReg)) else $error("result moved"); // R10
  AST_FLAG_FROM_CONV: assert property (@(posedge clk) disable iff (!rstAll_n)
    $rose(flagBit) |-> ($past(seqState) == ST_CONV)) else $error("flag source"); // R6
  AST_BUSY_DROPS_AT_DONE: assert property (@(posedge clk) disable iff (!rstAll_n)
    (seqState == ST_GAP && $past(seqState) == ST_CONV) |-> !busyBit) else $error("busy"); // R6
  AST_GAP_NO_ACQ: assert property (@(posedge clk) disable iff (!rstAll_n)
    (seqState == ST_GAP) |=> (seqState == ST_GAP || seqState == ST_IDLE)) else $error("gap"); // R8
  AST_CHAN_FROZEN: assert property (@(posedge clk) disable iff (!rstAll_n)
    (seqState != ST_IDLE) |=> $stable(chanSel)) else $error("chan"); // R9
  AST_SH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstAll_n)
    sampleHold |-> busyBit) else $error("sample"); // R4
  AST_OFF_IS_IDLE: assert property (@(posedge clk) disable iff (!rstAll_n)
    !enableBit |-> (seqState == ST_IDLE && !busyBit)) else $error("off"); // R10
endmodule

bind sar_adc_seq sar_seq_chk #(.RES_W(RES_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rstAll_n(rstAll_n), .seqState(seqState), .busyBit(busyBit),
  .enableBit(enableBit), .flagBit(flagBit), .sampleHold(sampleHold),
  .chanSel(chanSel), .resultReg(resultReg)
);

// File: tb/sar_adc_seq_bench.sv
`timescale 1ns/1ps
module sar_adc_seq_bench;
  logic        clk = 1'b0;
  logic        porRst_n = 1'b0, sysRst_n = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        cmpHigh;
  logic [11:0] dacCode;
  logic [3:0]  chanSel;
  logic        sampleHold, irq;

  logic [11:0] vin [16];
  int nVec = 0, nErr = 0, cyc = 0, wdog = 0;

  // reference model state
  bit mEn, mBusy, mFlag, mIe, mGie, mActive, mSH;
  int mCh, mDiv, mAcq, mLatCh, mStart, mA, mD;
  int mResult;

  always #5 clk = ~clk;

  assign cmpHigh = (vin[chanSel] >= dacCode);

  sar_adc_seq u_sar_adc_seq (
    .clk(clk), .porRst_n(porRst_n), .sysRst_n(sysRst_n), .regAddr(regAddr),
    .regWe(regWe), .regWrData(regWrData), .regRdData(regRdData),
    .cmpHigh(cmpHigh), .dacCode(dacCode), .chanSel(chanSel),
    .sampleHold(sampleHold), .irq(irq)
  );

  function automatic int acqLen(int code);
    case (code)
      0: return 0;  1: return 2;  2: return 4;  3: return 6;
      4: return 8;  5: return 12; 6: return 16; default: return 20;
    endcase
  endfunction

  function automatic int tcLen(int sel);
    return (sel >= 5) ? 64 : (2 << sel);
  endfunction

  task automatic chk(input int got, input int exp, input string tag);
    nVec++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // reference model, advanced at each rising edge
  always @(posedge clk) begin
    bit oldBusy, oldEn, doneNow;
    if (!porRst_n) mResult = 0;
    if (!porRst_n || !sysRst_n) begin
      mEn = 0; mBusy = 0; mFlag = 0; mIe = 0; mGie = 0; mActive = 0;
      mSH = 0; mCh = 0; mDiv = 0; mAcq = 0; mLatCh = 0;
    end else begin
      cyc++;
      oldBusy = mBusy; oldEn = mEn; doneNow = 0;
      if (mActive) begin
        if (cyc - mStart == (mA + 12) * mD) begin
          mBusy = 0; mFlag = 1; mResult = int'(vin[mLatCh]); doneNow = 1;
        end
        if (cyc - mStart == (mA + 14) * mD) mActive = 0;
      end else if (oldBusy && oldEn) begin
        mActive = 1; mStart = cyc; mLatCh = mCh;
        mA = acqLen(mAcq); mD = tcLen(mDiv);
      end
      if (regWe) begin
        case (regAddr)
          3'd0: begin
            mEn = regWrData[0];
            mCh = int'(regWrData[5:2]);
            if (!regWrData[0]) begin mActive = 0; mBusy = 0; end
            else if (regWrData[1] && !oldBusy) mBusy = 1;
          end
          3'd1: begin mDiv = int'(regWrData[2:0]); mAcq = int'(regWrData[5:3]); end
          3'd2: begin
            mIe = regWrData[1]; mGie = regWrData[2];
            if (!regWrData[0] && !doneNow) mFlag = 0;
          end
          default: ;
        endcase
      end
      mSH = mActive && ((cyc - mStart) < mA * mD);
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (porRst_n && sysRst_n) begin
      chk(int'(irq), int'(mFlag & mIe & mGie), "R7 irq");
      chk(int'(sampleHold), int'(mSH), "R4 sampleHold");
      chk(int'(chanSel), mLatCh, "R9 chanSel");
      if (regAddr == 3'd0)
        chk(int'(regRdData), (mCh << 2) | (int'(mBusy) << 1) | int'(mEn), "R2 control/busy");
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  endtask

  always @(posedge clk) begin
    wdog++;
    if (wdog > 150000) begin
      nErr++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", wdog);
      finishRun();
    end
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk); #2;
    regAddr = 3'(addr); regWe = 1'b1; regWrData = 8'(data);
    @(posedge clk); #2;
    regWe = 1'b0; regAddr = 3'd0;
  endtask

  task automatic rd(input int addr, output int val);
    @(negedge clk); #2;
    regAddr = 3'(addr); #1;
    val = int'(regRdData);
    #1 regAddr = 3'd0;
  endtask

  task automatic readResult(output int val);
    int hi, lo;
    rd(3, hi); rd(4, lo);
    val = (hi << 8) | lo;
  endtask

  task automatic waitIdle();
    while (mActive || mBusy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic runConv(input int ch, input int sel, input int acq, input string tag);
    int n, res;
    wr(1, (acq << 3) | sel);
    wr(0, (ch << 2) | 3);
    n = 0;
    forever begin
      @(negedge clk);
      if (regRdData[1]) n++; else break;
    end
    chk(n, (acqLen(acq) + 12) * tcLen(sel) + 1, "R3 busy length");
    readResult(res);
    chk(res, int'(vin[ch]), tag);
    waitIdle();
  endtask

  initial begin
    int v, keep;
    vin[0] = 12'h000; vin[3] = 12'hA5C; vin[7] = 12'h3C1; vin[9] = 12'h555;
    vin[15] = 12'hFFF; vin[5] = 12'hAAA;
    for (int i = 1; i < 16; i++) if (!(i inside {3, 5, 7, 9, 15})) vin[i] = 12'(i * 37);
    repeat (3) @(negedge clk);
    #2 porRst_n = 1'b1; sysRst_n = 1'b1;

    // R1 reset state and map
    for (int a = 0; a < 3; a++) begin rd(a, v); chk(v, 0, "R1 reset register"); end
    rd(5, v); chk(v, 0, "R1 unmapped address");
    chk(int'(irq), 0, "R1 reset irq");
    chk(int'(sampleHold), 0, "R1 reset sampleHold");
    wr(1, 8'h3D); rd(1, v); chk(v, 8'h3D, "R1 timing readback");
    wr(2, 8'h06); rd(2, v); chk(v, 8'h06, "R1 interrupt readback");
    wr(0, 8'h01);

    // R5 main function across codes, dividers and acquisition lengths
    runConv(3, 0, 0, "R5 mid code");
    chk(int'(irq), 1, "R7 irq after done");
    rd(2, v); chk(v & 1, 1, "R6 flag set");
    wr(2, 8'h06); chk(int'(irq), 0, "R7 flag cleared");
    runConv(15, 5, 7, "R5 full scale");
    runConv(0, 2, 5, "R5 zero code");
    runConv(7, 6, 1, "R3 clamp select 6");
    runConv(9, 7, 3, "R3 clamp select 7");
    runConv(5, 1, 2, "R5 alternating code");

    // R7 gating and clear-only flag write
    wr(2, 8'h02);
    runConv(3, 0, 1, "R7 result");
    chk(int'(irq), 0, "R7 global enable off");
    rd(2, v); chk(v & 1, 1, "R7 flag pending");
    wr(2, 8'h00); rd(2, v); chk(v & 1, 0, "R7 cleared");
    wr(2, 8'h01); rd(2, v); chk(v & 1, 0, "R7 write one does not set");
    wr(2, 8'h06);

    // R9 restart and channel change while busy
    wr(1, (2 << 3) | 1);
    wr(0, (3 << 2) | 3);
    repeat (10) @(negedge clk);
    wr(0, (15 << 2) | 3);
    chk(int'(chanSel), 3, "R9 chanSel held");
    waitIdle();
    readResult(v); chk(v, int'(vin[3]), "R9 channel kept");
    repeat (40) @(negedge clk);
    chk(int'(sampleHold), 0, "R9 no second conversion");
    wr(2, 8'h06);

    // R8 start queued in the gap
    wr(1, (2 << 3) | 0);
    wr(0, (7 << 2) | 3);
    while (regRdData[1]) @(negedge clk);
    wr(0, (9 << 2) | 3);
    chk(int'(sampleHold), 0, "R8 held during gap");
    waitIdle();
    readResult(v); chk(v, int'(vin[9]), "R8 queued conversion");
    wr(2, 8'h06);

    // R10 abort and start while disabled
    readResult(keep);
    wr(1, (4 << 3) | 3);
    wr(0, (3 << 2) | 3);
    repeat (200) @(negedge clk);
    wr(0, 3 << 2);
    chk(int'(regRdData[1]), 0, "R10 busy dropped");
    chk(int'(sampleHold), 0, "R10 sample open");
    repeat (500) @(negedge clk);
    readResult(v); chk(v, keep, "R10 result untouched");
    rd(2, v); chk(v & 1, 0, "R10 no flag");
    wr(0, 8'h02); chk(int'(regRdData[1]), 0, "R10 start ignored when off");

    // R11 reset domains
    wr(0, 8'h01);
    runConv(15, 0, 0, "R11 preload");
    @(negedge clk); #2 sysRst_n = 1'b0;
    repeat (3) @(negedge clk); #2 sysRst_n = 1'b1;
    for (int a = 0; a < 3; a++) begin rd(a, v); chk(v, 0, "R11 general reset"); end
    readResult(v); chk(v, 12'hFFF, "R11 result survives");
    @(negedge clk); #2 porRst_n = 1'b0;
    repeat (3) @(negedge clk); #2 porRst_n = 1'b1;
    readResult(v); chk(v, 0, "R11 power-on clears result");

    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule